// File: doc/BRIEF.md
# Joypad Select-and-Sense Port

This block is an 8-bit joypad port register sitting on a CPU register bus. Software writes two active-low select lines into bits 5:4. The block answers in bits 3:0 with four active-low sense lines taken from an 8-bit vector of pressed keys. The vector holds two groups of four keys: the low group in bits 3:0 and the high group in bits 7:4. A pressed key reads as 0.

The sense lines are re-sampled on every clock, so a key press alone, with no CPU access, can pull a line low. Any line that falls from 1 to 0 produces a one-cycle keypad interrupt pulse. When a nonzero multiplayer controller index is applied, the key vector counts as fully released. With both select lines high, the port returns the controller index instead of keys. An optional read filter hides a pair of opposing directions that are pressed together when the high group is selected.

Top module: `joypad_port`

## Requirements
- R1: While reset is low, and after the first clock edge of reset, `rd_data` reads 0xFF and `irq_o` is 0. This means the select field is 11 and all sense lines are 1.
- R2: With the stored select field equal to 01 (bit 5 = 0, bit 4 = 1), `rd_data[3:0]` is the bitwise inverse of `keys_i[3:0]`.
- R3: With select 10 (bit 5 = 1, bit 4 = 0), `rd_data[3:0]` is the inverse of `keys_i[7:4]`.
- R4: With select 00, `rd_data[3:0]` is the inverse of `keys_i[3:0] | keys_i[7:4]`.
- R5: With select 11, `rd_data[3:0]` is the inverse of `ctrl_idx`, zero-extended to four bits.
- R6: While `ctrl_idx` is nonzero, selects 00, 01 and 10 read 1111 in bits 3:0, whatever `keys_i` holds.
- R7: `rd_data[7:6]` always read 11. `rd_data[5:4]` read the select bits of the last write. The other bits of a written byte are ignored.
- R8: `irq_o` is high for exactly one cycle, in the cycle after a sense line falls from 1 to 0. For this rule, a CPU write counts as resetting all four lines to 1 before they are re-evaluated.
- R9: `irq_o` stays 0 when the sense lines only rise or stay the same, with no write.
- R10: With `filter_en` high and select 10, a pair of lines that both read 0 reads 11 instead. The pairs are bits 1:0 and bits 3:2. Other selects, or `filter_en` low, read unfiltered. The filter never changes the interrupt.
- R11: Sense lines follow `keys_i` and `ctrl_idx` one clock edge later without any CPU access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for the port register |
| wr_data | input | 8 | CPU write data; only bits 5:4 are kept |
| rd_data | output | 8 | Current register read value |
| keys_i | input | 8 | Pressed-key vector, active high, two groups of four |
| ctrl_idx | input | CTRL_W | Multiplayer controller index |
| filter_en | input | 1 | Enable for the opposing-direction read filter |
| irq_o | output | 1 | One-cycle keypad interrupt pulse |

## Verification
A corrupted select field shows up at the next read as a wrong value in bits 5:4. It also routes the wrong key group into bits 3:0, so the error is visible in the same cycle as the read. A stale or wrong sense-line register shows up in bits 3:0 one edge after the keys change. It also produces either a spurious `irq_o` pulse or a missing one in that same cycle. Because the pulse lasts only one cycle, the bench samples `irq_o` in the exact cycle after each stimulus and again one cycle later.

// File: rtl/joypad_pkg.sv
// Shared types for the joypad port: select encodings and group width.
package joypad_pkg;
    localparam int GRP_W = 4;  // keys per group, also sense-line count

    typedef enum logic [1:0] {
        SEL_BOTH  = 2'b00,
        SEL_LOW   = 2'b01,
        SEL_HIGH  = 2'b10,
        SEL_IDENT = 2'b11
    } jp_sel_e;
endpackage

// File: rtl/joypad_key_mux.sv
// Picks which pressed keys drive the sense lines for a given select.
// Assumes CTRL_W <= GRP_W; a nonzero controller index masks all keys.
module joypad_key_mux
    import joypad_pkg::*;
#(
    parameter int CTRL_W = 2
) (
    input  jp_sel_e             sel,
    input  logic [2*GRP_W-1:0]  keys,
    input  logic [CTRL_W-1:0]   ctrl_idx,
    output logic [GRP_W-1:0]    pressed
);
    logic [2*GRP_W-1:0] keys_eff;
    logic [GRP_W-1:0]   id_nib;

    // Release every key while another controller is addressed
    always_comb begin
        keys_eff = (ctrl_idx != '0) ? '0 : keys;
        id_nib   = GRP_W'(ctrl_idx);
    end

    // Route the chosen group, the merged groups or the controller id
    always_comb begin
        unique case (sel)
            SEL_LOW:   pressed = keys_eff[GRP_W-1:0];
            SEL_HIGH:  pressed = keys_eff[2*GRP_W-1:GRP_W];
            SEL_BOTH:  pressed = keys_eff[GRP_W-1:0] | keys_eff[2*GRP_W-1:GRP_W];
            default:   pressed = id_nib;
        endcase
    end
endmodule

// File: rtl/joypad_dir_filter.sv
// Read-side filter hiding opposing directions pressed together.
// Assumes sense lines come in adjacent pairs of opposite directions.
module joypad_dir_filter
    import joypad_pkg::*;
(
    input  logic             enable,
    input  jp_sel_e          sel,
    input  logic [GRP_W-1:0] lines_in,
    output logic [GRP_W-1:0] lines_out
);
    localparam int PAIRS = GRP_W / 2;

    logic active;

    // Filter only acts on the direction group
    always_comb active = enable && (sel == SEL_HIGH);

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        // Force a fully-low pair back to released
        always_comb begin
            if (active && lines_in[2*p+1 -: 2] == 2'b00)
                lines_out[2*p+1 -: 2] = 2'b11;
            else
                lines_out[2*p+1 -: 2] = lines_in[2*p+1 -: 2];
        end
    end
endmodule

// File: rtl/joypad_fall_detect.sv
// Registers a one-cycle pulse when any sense line goes from 1 to 0.
// Assumes prev and next are the old and new register values.
module joypad_fall_detect
    import joypad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] prev,
    input  logic [GRP_W-1:0] next,
    output logic             pulse
);
    // Capture whether this update lowers any line
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= |(prev & ~next);
    end
endmodule

// File: rtl/joypad_port.sv
// Joypad select-and-sense port register with keypad interrupt.
// Sense lines are re-evaluated every cycle; a write resets the lines to 1
// before evaluation. Reads are combinational from stored state.
module joypad_port
    import joypad_pkg::*;
#(
    parameter int CTRL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [7:0]        keys_i,
    input  logic [CTRL_W-1:0] ctrl_idx,
    input  logic              filter_en,
    output logic              irq_o
);
    localparam int SEL_LSB = GRP_W;

    jp_sel_e          sel_q;
    jp_sel_e          sel_nx;
    logic [GRP_W-1:0] line_q;
    logic [GRP_W-1:0] line_prev;
    logic [GRP_W-1:0] line_nx;
    logic [GRP_W-1:0] pressed;
    logic [GRP_W-1:0] line_rd;

    // A write takes effect in the same evaluation it triggers
    always_comb begin
        sel_nx    = wr_en ? jp_sel_e'(wr_data[SEL_LSB+1:SEL_LSB]) : sel_q;
        line_prev = wr_en ? '1 : line_q;
        line_nx   = ~pressed;
    end

    joypad_key_mux #(.CTRL_W(CTRL_W)) mux_i (
        .sel      (sel_nx),
        .keys     (keys_i),
        .ctrl_idx (ctrl_idx),
        .pressed  (pressed)
    );

    // Hold the select field and the evaluated sense lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= SEL_IDENT;
            line_q <= '1;
        end else begin
            sel_q  <= sel_nx;
            line_q <= line_nx;
        end
    end

    joypad_fall_detect fall_i (
        .clk   (clk),
        .rst_n (rst_n),
        .prev  (line_prev),
        .next  (line_nx),
        .pulse (irq_o)
    );

    joypad_dir_filter filt_i (
        .enable    (filter_en),
        .sel       (sel_q),
        .lines_in  (line_q),
        .lines_out (line_rd)
    );

    // Assemble the read value with the unused top bits high
    always_comb rd_data = {2'b11, sel_q, line_rd};
endmodule

// File: rtl/joypad_port_chk.sv
// Checker for joypad_port, bound onto every instance.
module joypad_port_chk #(
    parameter int CTRL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [7:0]        rd_data,
    input logic [CTRL_W-1:0] ctrl_idx,
    input logic              filter_en,
    input logic              irq_o,
    input logic [1:0]        sel_q,
    input logic [3:0]        line_q
);
    // R1: reset leaves the register at all ones with no interrupt
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 8'hFF && !irq_o));

    // R7: a write updates only the readable select field
    a_r7_sel_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[5:4] == $past(wr_data[5:4]));

    // R8: a pulse needs a falling line, unless a write preceded it
    a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !$past(wr_en)) |-> (($past(line_q) & ~line_q) != 4'h0));

    // R9: unchanged lines without a write never interrupt
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && line_q == $past(line_q)) |-> !irq_o);

    // R10: no opposing pair reads fully low when filtering the direction group
    a_r10_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (filter_en && sel_q == 2'b10) |-> (rd_data[1:0] != 2'b00 && rd_data[3:2] != 2'b00));

    // R6: another controller selected means all keys released
    a_r6_ctrl_masks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_idx) != '0 && !$past(wr_en) && sel_q != 2'b11) |-> rd_data[3:0] == 4'hF);
endmodule

bind joypad_port joypad_port_chk #(.CTRL_W(CTRL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .ctrl_idx  (ctrl_idx),
    .filter_en (filter_en),
    .irq_o     (irq_o),
    .sel_q     (sel_q),
    .line_q    (line_q)
);

// File: tb/joypad_port_tb_top.sv
// Self-checking bench for joypad_port.
module joypad_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] keys_i = 8'h00;
    logic [1:0] ctrl_idx = 2'd0;
    logic       filter_en = 1'b0;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    joypad_port #(.CTRL_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .keys_i(keys_i), .ctrl_idx(ctrl_idx),
        .filter_en(filter_en), .irq_o(irq_o)
    );

    // Fields: sel[20:19] keys[18:11] ctrl[10:9] filt[8] exp[7:4] req[3:0]
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {2'b01, 8'h05, 2'd0, 1'b0, 4'hA, 4'd2},  // R2 low group
        {2'b01, 8'h50, 2'd0, 1'b0, 4'hF, 4'd2},  // R2 high keys invisible
        {2'b10, 8'h50, 2'd0, 1'b0, 4'hA, 4'd3},  // R3 high group
        {2'b10, 8'h3C, 2'd0, 1'b0, 4'hC, 4'd3},  // R3 shifted down
        {2'b00, 8'h21, 2'd0, 1'b0, 4'hC, 4'd4},  // R4 merged
        {2'b00, 8'h84, 2'd0, 1'b0, 4'h3, 4'd4},  // R4 merged
        {2'b11, 8'hFF, 2'd2, 1'b0, 4'hD, 4'd5},  // R5 controller id
        {2'b11, 8'h00, 2'd0, 1'b0, 4'hF, 4'd5},  // R5 id zero
        {2'b01, 8'hFF, 2'd1, 1'b0, 4'hF, 4'd6},  // R6 keys masked
        {2'b10, 8'h30, 2'd0, 1'b1, 4'hF, 4'd10}, // R10 horizontal pair
        {2'b10, 8'h30, 2'd0, 1'b0, 4'hC, 4'd10}, // R10 filter off
        {2'b10, 8'hC0, 2'd0, 1'b1, 4'hF, 4'd10}, // R10 vertical pair
        {2'b10, 8'h50, 2'd0, 1'b1, 4'hA, 4'd10}, // R10 no pair low
        {2'b01, 8'h03, 2'd0, 1'b1, 4'hC, 4'd10}  // R10 other select
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_sel(input logic [1:0] s);
        wr_en   = 1'b1;
        wr_data = {2'b00, s, 4'h0};
        step();
        wr_en   = 1'b0;
    endtask

    // Watchdog ends a hung run as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        check("R1 reset read", rd_data, 8'hFF);
        check("R1 reset irq", {7'd0, irq_o}, 8'h00);
        rst_n = 1'b1;
        step();
        check("R1 idle after reset", rd_data, 8'hFF);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            keys_i    = VEC[i][18:11];
            ctrl_idx  = VEC[i][10:9];
            filter_en = VEC[i][8];
            write_sel(VEC[i][20:19]);
            step();
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rd_data,
                  {2'b11, VEC[i][20:19], VEC[i][7:4]});
        end

        // R7: stray bits of a write are dropped
        keys_i = 8'h00; ctrl_idx = 2'd0; filter_en = 1'b0;
        wr_en = 1'b1; wr_data = 8'hCF;
        step();
        wr_en = 1'b0;
        check("R7 stray bits ignored", rd_data, 8'hCF);
        step();

        // R11 / R8 / R9: key press without CPU access
        write_sel(2'b01);
        step();
        step();
        check("R9 settled no irq", {7'd0, irq_o}, 8'h00);
        keys_i = 8'h08;
        check("R11 not yet sampled", rd_data, 8'hDF);
        step();
        check("R11 line follows key", rd_data, 8'hD7);
        check("R8 pulse on fall", {7'd0, irq_o}, 8'h01);
        step();
        check("R8 pulse one cycle", {7'd0, irq_o}, 8'h00);
        keys_i = 8'h00;
        step();
        check("R9 release no irq", {7'd0, irq_o}, 8'h00);
        check("R11 line released", rd_data, 8'hDF);

        // R8: write re-arms the lines, held key interrupts again
        keys_i = 8'h02;
        step();
        step();
        check("R8 held key idle", {7'd0, irq_o}, 8'h00);
        write_sel(2'b01);
        check("R8 write-induced pulse", {7'd0, irq_o}, 8'h01);
        step();
        check("R8 write pulse ends", {7'd0, irq_o}, 8'h00);

        // R6: other controller selected releases held key without irq
        ctrl_idx = 2'd1;
        step();
        check("R6 mask read", rd_data, 8'hDF);
        check("R9 mask no irq", {7'd0, irq_o}, 8'h00);

        // R10: filter does not affect interrupt on the direction group
        ctrl_idx = 2'd0; keys_i = 8'h00; filter_en = 1'b1;
        write_sel(2'b10);
        step();
        keys_i = 8'h30;
        step();
        check("R10 filtered read", rd_data, 8'hEF);
        check("R10 irq unfiltered", {7'd0, irq_o}, 8'h01);

        // R1: reset mid-run
        rst_n = 1'b0;
        step();
        check("R1 mid-run reset", rd_data, 8'hFF);
        check("R1 mid-run irq", {7'd0, irq_o}, 8'h00);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule